// File: doc/BRIEF.md
# Tiled Single-Port Memory Wrapper

This block presents one logical memory of 128-bit words, 2048 deep, with a single synchronous port: clock, chip select, write enable, address, write data, a per-byte write mask and read data. Internally the storage is assembled from smaller leaf memories. Leaves placed side by side make up the word width. Two such rows, each called a bank, make up the depth. The wrapper slices the write data across the leaves and decodes the bank from the address. It also selects the returned word with a multiplexer on the leaf outputs.

The leaves have no mask pin. When byte masking is wanted (`MASK_EMU=1`), each word is split into sixteen 8-bit lanes. The mask gates each lane's write enable on its own, so a bank holds sixteen byte-wide leaves. With masking off, each bank uses two 64-bit leaves and every write stores the whole word. The leaf chip-enable, write-enable and read-enable pins can each be active high or active low, chosen by a parameter. The wrapper drives them at the level that each polarity needs. Its own ports are always active high.

Top module: `tiled_sram_wrap`

## Requirements
- R1: A read is issued on a rising edge with `cs`=1 and `we`=0. From that edge on, `rdata` shows the most recently written contents of the addressed word, so the read latency is one cycle.
- R2: In the masked build, a write with `cs`=1 and `we`=1 stores byte b (bits 8b+7..8b) only when `wmask[b]`=1. All other bytes of the word keep their old value. A mask of zero stores nothing.
- R3: In the unmasked build, a write stores all 128 bits and `wmask` has no effect.
- R4: `addr[10]` selects one of two banks and `addr[9:0]` selects the word within it. All 2048 addresses are separate words, including 1023 and 1024 on either side of the bank boundary.
- R5: `rdata` keeps the value of the last read for as long as no new read is issued. This holds through idle cycles, through writes and while the address changes.
- R6: The output multiplexer uses the bank that was captured with the read. Back-to-back reads that alternate between banks each return their own word.
- R7: A leaf write enable is active only together with that leaf's chip enable, and only for the bank selected by the address. A leaf never has write enable and read enable active together.
- R8: Behaviour at the ports is the same for every combination of leaf pin polarities.
- R9: Reset does not alter stored words. While `rst_n` is low the bank selection returns to bank 0, so `rdata` shows bank 0's last read word.
- R10: With `cs`=0, nothing is written, even when `we`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the bank-selection register |
| cs | input | 1 | Access request, active high |
| we | input | 1 | 1 = write, 0 = read, when `cs`=1 |
| addr | input | 11 | Word address; top bit picks the bank |
| wdata | input | 128 | Write data |
| wmask | input | 16 | Per-byte write mask, bit b covers byte b (masked build only) |
| rdata | output | 128 | Read data, valid from the edge after the read is issued |

## Verification
The assertions assume that `rst_n` is already synchronous to `clk` on release. They also assume that `cs` stays low during reset, so the first sampled read after reset is a real one. The leaf checks rely on the wrapper's own decode, so they hold for any input sequence. The bench changes inputs only on the falling edge and keeps `cs` low throughout every reset pulse. It fills all 2048 words before its first read, so no comparison ever involves unwritten storage.

// File: rtl/tile_pkg.sv
package tile_pkg;
  // Turn a logical enable into the level a leaf pin expects.
  function automatic logic drive_pin(input logic active, input bit act_low);
    return act_low ? ~active : active;
  endfunction

  // Decode a leaf pin level back into a logical enable.
  function automatic logic sense_pin(input logic level, input bit act_low);
    return act_low ? ~level : level;
  endfunction
endpackage

// File: rtl/tile_leaf_ram.sv
module tile_leaf_ram #(
  parameter int AW         = 10,
  parameter int DW         = 8,
  parameter bit CE_ACT_LOW = 1'b1,
  parameter bit WE_ACT_LOW = 1'b1,
  parameter bit RE_ACT_LOW = 1'b0
) (
  input  logic          clk,
  input  logic          ce_pin,
  input  logic          we_pin,
  input  logic          re_pin,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  import tile_pkg::*;

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];
  logic          ce_on, we_on, re_on;
  logic          do_wr, do_rd;

  always_comb begin
    ce_on = sense_pin(ce_pin, CE_ACT_LOW);
    we_on = sense_pin(we_pin, WE_ACT_LOW);
    re_on = sense_pin(re_pin, RE_ACT_LOW);
    do_wr = ce_on && we_on;
    do_rd = ce_on && re_on && !we_on;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[addr] <= wdata;
  end

  // Output register holds between reads.
  always_ff @(posedge clk) begin
    if (do_rd) rdata <= mem[addr];
  end
endmodule

// File: rtl/tile_bank.sv
module tile_bank #(
  parameter int AW         = 10,
  parameter int LEAF_W     = 8,
  parameter int LANES      = 16,
  parameter bit CE_ACT_LOW = 1'b1,
  parameter bit WE_ACT_LOW = 1'b1,
  parameter bit RE_ACT_LOW = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sel_i,
  input  logic                    we_i,
  input  logic                    rd_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LEAF_W-1:0] wdata_i,
  input  logic [LANES-1:0]        lane_wr_i,
  output logic [LANES*LEAF_W-1:0] rdata_o
);
  import tile_pkg::*;

  localparam logic CE_ON = !CE_ACT_LOW;
  localparam logic WE_ON = !WE_ACT_LOW;
  localparam logic RE_ON = !RE_ACT_LOW;

  logic [LANES-1:0] ce_pin, we_pin, re_pin;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      ce_pin[l] = drive_pin(sel_i, CE_ACT_LOW);
      we_pin[l] = drive_pin(sel_i && we_i && lane_wr_i[l], WE_ACT_LOW);
      re_pin[l] = drive_pin(sel_i && rd_i, RE_ACT_LOW);
    end

    tile_leaf_ram #(
      .AW(AW), .DW(LEAF_W),
      .CE_ACT_LOW(CE_ACT_LOW), .WE_ACT_LOW(WE_ACT_LOW), .RE_ACT_LOW(RE_ACT_LOW)
    ) u_leaf (
      .clk   (clk),
      .ce_pin(ce_pin[l]),
      .we_pin(we_pin[l]),
      .re_pin(re_pin[l]),
      .addr  (addr_i),
      .wdata (wdata_i[l*LEAF_W +: LEAF_W]),
      .rdata (rdata_o[l*LEAF_W +: LEAF_W])
    );

    a_r7_we_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
      (we_pin[l] == WE_ON) |-> (ce_pin[l] == CE_ON));
    a_r7_we_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |-> (we_pin[l] != WE_ON));
    a_r7_no_we_with_re: assert property (@(posedge clk) disable iff (!rst_n)
      !((we_pin[l] == WE_ON) && (re_pin[l] == RE_ON)));
    a_r2_lane_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (we_pin[l] == WE_ON) |-> lane_wr_i[l]);
  end
endmodule

// File: rtl/tile_rd_mux.sv
module tile_rd_mux #(
  parameter int DATA_W = 128,
  parameter int BANK_W = 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rd_i,
  input  logic [BANK_W-1:0]                    bank_i,
  input  logic [(1<<BANK_W)-1:0][DATA_W-1:0]   bank_data_i,
  output logic [DATA_W-1:0]                    rdata_o
);
  logic [BANK_W-1:0] sel_q, sel_d;

  always_comb begin
    sel_d = sel_q;
    if (rd_i) sel_d = bank_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign rdata_o = bank_data_i[sel_q];

  a_r6_sel_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> (sel_q == $past(bank_i)));
  a_r6_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(sel_q));
endmodule

// File: rtl/tiled_sram_wrap.sv
module tiled_sram_wrap #(
  parameter int DATA_W      = 128,
  parameter int DEPTH       = 2048,
  parameter int LEAF_DEPTH  = 1024,
  parameter bit MASK_EMU    = 1'b1,
  parameter int WIDE_LEAF_W = 64,
  parameter bit CE_ACT_LOW  = 1'b1,
  parameter bit WE_ACT_LOW  = 1'b1,
  parameter bit RE_ACT_LOW  = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/8-1:0]      wmask,
  output logic [DATA_W-1:0]        rdata
);
  localparam int ADDR_W  = $clog2(DEPTH);
  localparam int LEAF_AW = $clog2(LEAF_DEPTH);
  localparam int BANK_W  = ADDR_W - LEAF_AW;
  localparam int NBANK   = 1 << BANK_W;
  localparam int LEAF_W  = MASK_EMU ? 8 : WIDE_LEAF_W;
  localparam int LANES   = DATA_W / LEAF_W;

  logic [BANK_W-1:0]                bank_idx;
  logic [LEAF_AW-1:0]               word_idx;
  logic                             rd_req;
  logic [LANES-1:0]                 lane_wr;
  logic [NBANK-1:0][DATA_W-1:0]     bank_rd;

  always_comb begin
    bank_idx = addr[ADDR_W-1:LEAF_AW];
    word_idx = addr[LEAF_AW-1:0];
    rd_req   = cs && !we;
  end

  if (MASK_EMU) begin : g_mask
    assign lane_wr = wmask;
  end else begin : g_nomask
    logic unused_mask;
    assign unused_mask = ^wmask;
    assign lane_wr     = '1;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_sel;
    assign bank_sel = cs && (bank_idx == BANK_W'(b));

    tile_bank #(
      .AW(LEAF_AW), .LEAF_W(LEAF_W), .LANES(LANES),
      .CE_ACT_LOW(CE_ACT_LOW), .WE_ACT_LOW(WE_ACT_LOW), .RE_ACT_LOW(RE_ACT_LOW)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_i    (bank_sel),
      .we_i     (we),
      .rd_i     (rd_req),
      .addr_i   (word_idx),
      .wdata_i  (wdata),
      .lane_wr_i(lane_wr),
      .rdata_o  (bank_rd[b])
    );
  end

  tile_rd_mux #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (rd_req),
    .bank_i     (bank_idx),
    .bank_data_i(bank_rd),
    .rdata_o    (rdata)
  );

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !we) |=> $stable(rdata));
endmodule

// File: tb/sim_tiled_sram_wrap.sv
module sim_tiled_sram_wrap;
  logic         clk = 1'b0;
  logic         rst_n, cs, we;
  logic [10:0]  addr;
  logic [127:0] wdata;
  logic [15:0]  wmask;
  logic [127:0] rd0, rd1, rd2;

  always #5 clk = ~clk;

  tiled_sram_wrap #(.MASK_EMU(1'b1), .CE_ACT_LOW(1'b1), .WE_ACT_LOW(1'b1), .RE_ACT_LOW(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata), .wmask(wmask), .rdata(rd0));
  tiled_sram_wrap #(.MASK_EMU(1'b1), .CE_ACT_LOW(1'b0), .WE_ACT_LOW(1'b0), .RE_ACT_LOW(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata), .wmask(wmask), .rdata(rd1));
  tiled_sram_wrap #(.MASK_EMU(1'b0), .CE_ACT_LOW(1'b1), .WE_ACT_LOW(1'b0), .RE_ACT_LOW(1'b1)) u2 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata), .wmask(wmask), .rdata(rd2));

  logic [127:0] ref_m [2048];
  logic [127:0] ref_u [2048];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic        wr;
    logic [10:0] a;
    logic [15:0] m;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 11'd1023, 16'hFFFF, 32'h1111_AAAA},
    '{1'b1, 11'd1024, 16'hFFFF, 32'h2222_BBBB},
    '{1'b0, 11'd1023, 16'h0000, 32'h0},
    '{1'b0, 11'd1024, 16'h0000, 32'h0},
    '{1'b1, 11'd5,    16'h00F0, 32'hDEAD_BEEF},
    '{1'b0, 11'd5,    16'h0000, 32'h0},
    '{1'b1, 11'd1030, 16'h0000, 32'hFFFF_FFFF},
    '{1'b0, 11'd1030, 16'h0000, 32'h0},
    '{1'b1, 11'd1030, 16'h8001, 32'h0123_4567},
    '{1'b0, 11'd1030, 16'h0000, 32'h0},
    '{1'b0, 11'd0,    16'h0000, 32'h0},
    '{1'b0, 11'd2047, 16'h0000, 32'h0},
    '{1'b0, 11'd1,    16'h0000, 32'h0},
    '{1'b0, 11'd2046, 16'h0000, 32'h0}
  };

  function automatic logic [127:0] merge(input logic [127:0] old, input logic [127:0] nw,
                                         input logic [15:0] m);
    logic [127:0] r = old;
    for (int b = 0; b < 16; b++) if (m[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [10:0] a, input logic [127:0] d, input logic [15:0] m);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d; wmask = m;
    @(posedge clk);
    ref_m[a] = merge(ref_m[a], d, m);
    ref_u[a] = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  // Issue a read, sample one edge later; R1 latency, R8 all polarities agree.
  task automatic do_read(input logic [10:0] a, input string req);
    cs = 1'b1; we = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk);
    cs = 1'b0;
    check({req, " u0"}, rd0, ref_m[a]);
    check({req, " u1 R8"}, rd1, ref_m[a]);
    check({req, " u2 R3"}, rd2, ref_u[a]);
  endtask

  initial begin
    logic [127:0] h0, h1, h2;
    rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0; wmask = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 2048; i++)
      do_write(11'(i), {4{32'h5A00_0000 | 32'(i)}}, 16'hFFFF);

    // Vector table: R1, R2, R3, R4, R6 (back-to-back cross-bank reads)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) do_write(VEC[i].a, {4{VEC[i].d}}, VEC[i].m);
      else           do_read(VEC[i].a, "R1 R2 R4 R6 vector");
    end

    // R10: write attempt with cs low
    cs = 1'b0; we = 1'b1; addr = 11'd7; wdata = '1; wmask = '1;
    @(negedge clk);
    we = 1'b0;
    do_read(11'd7, "R10 cs low");

    // R5: hold through idle, address change and a write
    do_read(11'd1024, "R5 setup");
    h0 = rd0; h1 = rd1; h2 = rd2;
    addr = 11'd0;
    @(negedge clk);
    check("R5 idle u0", rd0, h0);
    do_write(11'd3, '0, 16'hFFFF);
    check("R5 after write u0", rd0, h0);
    check("R5 after write u1", rd1, h1);
    check("R5 after write u2", rd2, h2);

    // R9: reset returns bank selection to bank 0, contents kept
    do_read(11'd9, "R9 setup bank0");
    do_read(11'd1500, "R9 setup bank1");
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset sel bank0 u0", rd0, ref_m[9]);
    check("R9 reset sel bank0 u2", rd2, ref_u[9]);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(11'd1500, "R9 contents kept");

    // Random traffic: R1 R2 R3 R4 R8
    for (int i = 0; i < 3000; i++) begin
      logic [10:0] a = 11'($urandom_range(0, 2047));
      if ($urandom_range(0, 1) == 1)
        do_write(a, {$urandom, $urandom, $urandom, $urandom}, 16'($urandom));
      else
        do_read(a, "R2 R4 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule